// File: doc/BRIEF.md
# Register Bit Test and Manipulation Unit

This block holds a small register file and performs single-bit operations on any one of its entries. The file contains four 40-bit accumulators, eight 16-bit auxiliary registers and four 16-bit temporary registers. An operation names a target register, an operation code and a bit position. The unit can test a bit, set it, clear it, invert it, or test a pair of adjacent bits. The bit position is either a small immediate constant or the low 16 bits of an auxiliary register used as a pointer.

Each operation returns its result one clock later. The result is the target's value after the operation, plus two condition flags that persist between operations. Positions that fall outside the target's width, and undefined operation codes, raise a one-cycle error and change nothing. A separate load port writes whole registers. It can be used in the same cycle as an operation, and fixed rules decide which write wins.

Top module: `bitop_unit`

## Requirements
- R1: After reset every register reads as zero, both condition flags are 0, and `res_valid` and `op_err` are low.
- R2: A load writes `ld_data` into the selected register. The 16-bit registers keep only bits 15:0, and the upper bits read back as zero.
- R3: Set (code 1), clear (code 2) and invert (code 3) at position n change only bit n of the target. `res_value` shows the new value and both flags keep their values.
- R4: A single-bit test (code 0) at position n copies bit n into `tc1`. It leaves `tc2` and the register unchanged, and `res_value` shows the unchanged register.
- R5: A pair test (code 4) at position n copies bit n into `tc1` and bit n+1 into `tc2`. Position 30 of 0x007ADF3D05 gives `tc1`=1 and `tc2`=0.
- R6: When `op_use_ptr` is 1, the position is the low 16 bits of auxiliary register `op_ptr`. Otherwise the position is `op_imm`. Bit positions count from bit 0, the least significant bit.
- R7: An error is raised when the position is at least the target width (40 or 16), when a pair test's position+1 is at least the target width, or when the operation code is 5 to 7. In that case `op_err` pulses with the result, the register and both flags are left unchanged, and `res_value` shows the unchanged register.
- R8: Select codes 0–3 address accumulators 0–3, codes 4–11 address auxiliary registers 0–7, and codes 12–15 address temporary registers 0–3. The same codes apply to the load port and to operations.
- R9: `res_valid` is high in exactly the cycle after each cycle with `op_valid` high. Operations may issue back to back, and `op_err` is never high without `res_valid`.
- R10: A load and an operation may be issued in the same cycle. The operation reads the values from before the load, both for its target and for its pointer. If both write the same register, the set, clear or invert result wins. A load is kept when the operation is a test, has an error, or targets another register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 4 | Register select for the load |
| ld_data | input | 40 | Load value (truncated for 16-bit registers) |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 0 test, 1 set, 2 clear, 3 invert, 4 pair test |
| op_sel | input | 4 | Target register select |
| op_use_ptr | input | 1 | 1: position from an auxiliary register, 0: from immediate |
| op_imm | input | 6 | Immediate bit position |
| op_ptr | input | 3 | Index of the auxiliary register that holds the position |
| res_valid | output | 1 | Result available (one cycle after `op_valid`) |
| res_value | output | 40 | Target value after the operation, zero-extended |
| tc1 | output | 1 | First condition flag |
| tc2 | output | 1 | Second condition flag |
| op_err | output | 1 | Operation rejected |

## Verification
The load port and the operation path can act in the same cycle, and they can touch the same register, whether as a write target or as the pointer that supplies the position. The bench issues a load and a set on the same temporary register together, then reads that register back with a test. The expected value comes from the pre-load contents with the set applied, so the load is lost. It also reloads the pointer register in the same cycle as a pointer-driven test. That test must use the old position, and a later read of the pointer register must return the newly loaded value.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    BOP_TEST = 3'd0,
    BOP_SET  = 3'd1,
    BOP_CLR  = 3'd2,
    BOP_FLIP = 3'd3,
    BOP_PAIR = 3'd4
  } bop_e;

  localparam int LONG_W_DEF  = 40;
  localparam int SHORT_W_DEF = 16;
  localparam int N_ACC_DEF   = 4;
  localparam int N_AUX_DEF   = 8;
  localparam int N_TMP_DEF   = 4;

endpackage

// File: rtl/bitop_regfile.sv
// Mixed-width register file: long entries first, then pointer entries,
// then short scratch entries. The operation writeback takes precedence
// over the load port when both address the same entry.
module bitop_regfile
  import bitop_pkg::*;
#(
  parameter int LONG_W  = LONG_W_DEF,
  parameter int SHORT_W = SHORT_W_DEF,
  parameter int N_ACC   = N_ACC_DEF,
  parameter int N_AUX   = N_AUX_DEF,
  parameter int N_TMP   = N_TMP_DEF,
  localparam int N_REG  = N_ACC + N_AUX + N_TMP,
  localparam int SEL_W  = $clog2(N_REG),
  localparam int PTR_W  = $clog2(N_AUX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [SEL_W-1:0]   ld_sel,
  input  logic [LONG_W-1:0]  ld_data,
  input  logic               wb_en,
  input  logic [SEL_W-1:0]   wb_sel,
  input  logic [LONG_W-1:0]  wb_data,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [LONG_W-1:0]  rd_data,
  output logic               rd_long,
  input  logic [PTR_W-1:0]   ptr_sel,
  output logic [SHORT_W-1:0] ptr_data
);

  logic [LONG_W-1:0] view [N_REG];
  logic [SEL_W-1:0]  ptr_idx;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    localparam int W = (i < N_ACC) ? LONG_W : SHORT_W;
    logic [W-1:0] q;
    logic [W-1:0] d;
    logic         en;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (wb_en && (wb_sel == SEL_W'(i))) begin
        en = 1'b1;
        d  = wb_data[W-1:0];
      end else if (ld_en && (ld_sel == SEL_W'(i))) begin
        en = 1'b1;
        d  = ld_data[W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    if (W == LONG_W) begin : g_full
      assign view[i] = q;
    end else begin : g_short
      assign view[i] = {{(LONG_W - W){1'b0}}, q};
    end
  end

  assign rd_data  = view[rd_sel];
  assign rd_long  = (rd_sel < SEL_W'(N_ACC));
  assign ptr_idx  = SEL_W'(N_ACC) + SEL_W'(ptr_sel);
  assign ptr_data = view[ptr_idx][SHORT_W-1:0];

endmodule

// File: rtl/bitop_offset.sv
// Chooses the bit position and checks it against the target width.
module bitop_offset
  import bitop_pkg::*;
#(
  parameter int LONG_W  = LONG_W_DEF,
  parameter int SHORT_W = SHORT_W_DEF,
  localparam int POS_W  = $clog2(LONG_W)
) (
  input  logic [2:0]         op,
  input  logic               long_tgt,
  input  logic               use_ptr,
  input  logic [POS_W-1:0]   imm,
  input  logic [SHORT_W-1:0] ptr_val,
  output logic [POS_W-1:0]   pos,
  output logic               bad
);

  logic [SHORT_W-1:0] off;
  logic [SHORT_W:0]   need;
  logic [SHORT_W:0]   lim;
  logic               is_pair;
  logic               undefined_op;

  always_comb begin
    off          = use_ptr ? ptr_val : SHORT_W'(imm);
    is_pair      = (op == BOP_PAIR);
    undefined_op = (op > BOP_PAIR);
    need         = {1'b0, off} + {{SHORT_W{1'b0}}, is_pair};
    lim          = long_tgt ? (SHORT_W+1)'(LONG_W) : (SHORT_W+1)'(SHORT_W);
    bad          = undefined_op || (need >= lim);
    pos          = off[POS_W-1:0];
  end

endmodule

// File: rtl/bitop_alu.sv
// Computes the modified word and the two probed bits.
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int LONG_W = LONG_W_DEF,
  localparam int POS_W = $clog2(LONG_W)
) (
  input  logic [2:0]        op,
  input  logic [LONG_W-1:0] cur,
  input  logic [POS_W-1:0]  pos,
  output logic [LONG_W-1:0] nxt,
  output logic              bit_lo,
  output logic              bit_hi,
  output logic              writes,
  output logic              probe_lo,
  output logic              probe_hi
);

  logic [LONG_W-1:0] mask;
  logic [LONG_W-1:0] shifted;

  always_comb begin
    mask     = LONG_W'(1) << pos;
    shifted  = cur >> pos;
    bit_lo   = shifted[0];
    bit_hi   = shifted[1];
    nxt      = cur;
    writes   = 1'b0;
    probe_lo = 1'b0;
    probe_hi = 1'b0;
    case (op)
      BOP_SET:  begin nxt = cur | mask;  writes = 1'b1; end
      BOP_CLR:  begin nxt = cur & ~mask; writes = 1'b1; end
      BOP_FLIP: begin nxt = cur ^ mask;  writes = 1'b1; end
      BOP_TEST: probe_lo = 1'b1;
      BOP_PAIR: begin probe_lo = 1'b1; probe_hi = 1'b1; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int LONG_W  = LONG_W_DEF,
  parameter int SHORT_W = SHORT_W_DEF,
  parameter int N_ACC   = N_ACC_DEF,
  parameter int N_AUX   = N_AUX_DEF,
  parameter int N_TMP   = N_TMP_DEF,
  localparam int N_REG  = N_ACC + N_AUX + N_TMP,
  localparam int SEL_W  = $clog2(N_REG),
  localparam int PTR_W  = $clog2(N_AUX),
  localparam int POS_W  = $clog2(LONG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [LONG_W-1:0] ld_data,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [SEL_W-1:0]  op_sel,
  input  logic              op_use_ptr,
  input  logic [POS_W-1:0]  op_imm,
  input  logic [PTR_W-1:0]  op_ptr,
  output logic              res_valid,
  output logic [LONG_W-1:0] res_value,
  output logic              tc1,
  output logic              tc2,
  output logic              op_err
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic [LONG_W-1:0]  cur_val;
  logic               cur_long;
  logic [SHORT_W-1:0] ptr_val;
  logic [POS_W-1:0]   pos;
  logic               pos_bad;
  logic [LONG_W-1:0]  new_val;
  logic               bit_lo, bit_hi;
  logic               alu_writes, probe_lo, probe_hi;
  logic               wb_en;

  bitop_regfile #(
    .LONG_W (LONG_W), .SHORT_W(SHORT_W),
    .N_ACC  (N_ACC),  .N_AUX  (N_AUX), .N_TMP(N_TMP)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .wb_en   (wb_en),
    .wb_sel  (op_sel),
    .wb_data (new_val),
    .rd_sel  (op_sel),
    .rd_data (cur_val),
    .rd_long (cur_long),
    .ptr_sel (op_ptr),
    .ptr_data(ptr_val)
  );

  bitop_offset #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_offset (
    .op      (op_code),
    .long_tgt(cur_long),
    .use_ptr (op_use_ptr),
    .imm     (op_imm),
    .ptr_val (ptr_val),
    .pos     (pos),
    .bad     (pos_bad)
  );

  bitop_alu #(.LONG_W(LONG_W)) u_alu (
    .op      (op_code),
    .cur     (cur_val),
    .pos     (pos),
    .nxt     (new_val),
    .bit_lo  (bit_lo),
    .bit_hi  (bit_hi),
    .writes  (alu_writes),
    .probe_lo(probe_lo),
    .probe_hi(probe_hi)
  );

  // next-state for the result stage
  logic              valid_d, err_d, tc1_d, tc2_d;
  logic [LONG_W-1:0] value_d;
  logic              value_en, flag_en;
  logic              accept;

  always_comb begin
    accept   = op_valid && !pos_bad;
    wb_en    = accept && alu_writes;
    valid_d  = op_valid;
    err_d    = op_valid && pos_bad;
    value_en = op_valid;
    value_d  = wb_en ? new_val : cur_val;
    flag_en  = accept && probe_lo;
    tc1_d    = tc1;
    tc2_d    = tc2;
    if (flag_en) begin
      tc1_d = bit_lo;
      if (probe_hi) begin
        tc2_d = bit_hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_valid <= 1'b0;
      op_err    <= 1'b0;
    end else begin
      res_valid <= valid_d;
      op_err    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_value <= '0;
    end else if (value_en) begin
      res_value <= value_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tc1 <= 1'b0;
      tc2 <= 1'b0;
    end else if (flag_en) begin
      tc1 <= tc1_d;
      tc2 <= tc2_d;
    end
  end

endmodule

// File: rtl/bitop_checks.sv
module bitop_checks
  import bitop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [2:0] op_code,
  input logic       res_valid,
  input logic       tc1,
  input logic       tc2,
  input logic       op_err
);

  // R9: a result follows every issued operation
  a_r9_result_follows_op: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R9: no result without an operation
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  // R9, R7: error only accompanies a result
  a_r7_err_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> res_valid);

  // R7: rejected operations leave both flags alone
  a_r7_flags_frozen_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> ($stable(tc1) && $stable(tc2)));

  // R7: undefined codes are rejected
  a_r7_undefined_code: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code > BOP_PAIR)) |=> op_err);

  // R3: bit writes never touch the flags
  a_r3_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !op_err &&
     (($past(op_code) == BOP_SET) || ($past(op_code) == BOP_CLR) ||
      ($past(op_code) == BOP_FLIP)))
    |-> ($stable(tc1) && $stable(tc2)));

  // R4: a single-bit test leaves the second flag alone
  a_r4_test_keeps_tc2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !op_err && ($past(op_code) == BOP_TEST)) |-> $stable(tc2));

endmodule

bind bitop_unit bitop_checks u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .res_valid(res_valid),
  .tc1      (tc1),
  .tc2      (tc2),
  .op_err   (op_err)
);

// File: tb/bitop_unit_bench.sv
`timescale 1ns/1ps
module bitop_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [3:0]  ld_sel;
  logic [39:0] ld_data;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [3:0]  op_sel;
  logic        op_use_ptr;
  logic [5:0]  op_imm;
  logic [2:0]  op_ptr;
  logic        res_valid;
  logic [39:0] res_value;
  logic        tc1, tc2, op_err;

  always #4 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .op_valid(op_valid), .op_code(op_code), .op_sel(op_sel),
    .op_use_ptr(op_use_ptr), .op_imm(op_imm), .op_ptr(op_ptr),
    .res_valid(res_valid), .res_value(res_value),
    .tc1(tc1), .tc2(tc2), .op_err(op_err)
  );

  typedef struct {
    logic [39:0] v;
    logic        t1;
    logic        t2;
    logic        e;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [39:0] m [16];
  logic        m_tc1, m_tc2;
  int          n_cmp = 0;
  int          n_bad = 0;

  function automatic logic [39:0] trunc(input logic [3:0] s, input logic [39:0] d);
    return (s < 4) ? d : {24'h0, d[15:0]};
  endfunction

  task automatic issue(input bit le, input logic [3:0] ls, input logic [39:0] ldv,
                       input bit ov, input logic [2:0] oc, input logic [3:0] os,
                       input bit up, input logic [5:0] im, input logic [2:0] pp,
                       input string tag);
    exp_t        x;
    int          w, off;
    bit          bad, wr;
    logic [39:0] cur, nv;
    @(negedge clk);
    ld_en = le; ld_sel = ls; ld_data = ldv;
    op_valid = ov; op_code = oc; op_sel = os;
    op_use_ptr = up; op_imm = im; op_ptr = pp;
    wr = 1'b0; bad = 1'b0; nv = '0;
    if (ov) begin
      w   = (os < 4) ? 40 : 16;
      off = up ? int'(m[4 + int'(pp)][15:0]) : int'(im);
      bad = (oc > 3'd4) || ((oc == 3'd4) ? (off + 1 >= w) : (off >= w));
      cur = m[os];
      nv  = cur;
      if (!bad) begin
        case (oc)
          3'd0: m_tc1 = cur[off];
          3'd1: begin nv = cur | (40'd1 << off);  wr = 1'b1; end
          3'd2: begin nv = cur & ~(40'd1 << off); wr = 1'b1; end
          3'd3: begin nv = cur ^ (40'd1 << off);  wr = 1'b1; end
          default: begin m_tc1 = cur[off]; m_tc2 = cur[off + 1]; end
        endcase
      end
      x.v = nv; x.t1 = m_tc1; x.t2 = m_tc2; x.e = bad; x.tag = tag;
      sb.push_back(x);
    end
    if (le) m[ls] = trunc(ls, ldv);
    if (wr) m[os] = nv;
  endtask

  task automatic load(input logic [3:0] s, input logic [39:0] d);
    issue(1'b1, s, d, 1'b0, 3'd0, 4'd0, 1'b0, 6'd0, 3'd0, "");
  endtask

  task automatic op_i(input logic [2:0] c, input logic [3:0] s, input logic [5:0] im,
                      input string tag);
    issue(1'b0, 4'd0, 40'd0, 1'b1, c, s, 1'b0, im, 3'd0, tag);
  endtask

  task automatic op_p(input logic [2:0] c, input logic [3:0] s, input logic [2:0] p,
                      input string tag);
    issue(1'b0, 4'd0, 40'd0, 1'b1, c, s, 1'b1, 6'd0, p, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    ld_en = 1'b0; op_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [39:0] act,
                       input logic [39:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected result", res_value, 40'h0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(res_value == x.v, {x.tag, " value"}, res_value, x.v);
        check({tc1, tc2, op_err} == {x.t1, x.t2, x.e}, {x.tag, " tc1/tc2/err"},
              {37'h0, tc1, tc2, op_err}, {37'h0, x.t1, x.t2, x.e});
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ld_en = 1'b0; ld_sel = '0; ld_data = '0;
    op_valid = 1'b0; op_code = '0; op_sel = '0;
    op_use_ptr = 1'b0; op_imm = '0; op_ptr = '0;
    for (int i = 0; i < 16; i++) m[i] = '0;
    m_tc1 = 1'b0; m_tc2 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state at the ports, then a read of accumulator 0
    check({res_valid, op_err, tc1, tc2} == 4'b0000, "R1 reset outputs",
          {36'h0, res_valid, op_err, tc1, tc2}, 40'h0);
    op_i(3'd0, 4'd0, 6'd0, "R1 acc0 zero");
    op_i(3'd0, 4'd15, 6'd15, "R1 tmp3 zero");
    idle();

    // R5: pair test example
    load(4'd1, 40'h007ADF3D05);
    op_i(3'd4, 4'd1, 6'd30, "R5 pair at 30");
    // R2, R8: truncation on an auxiliary register
    load(4'd5, 40'hABCD123456);
    op_i(3'd0, 4'd5, 6'd0, "R2 R8 aux1 truncated");
    idle();

    // R3, R9: back-to-back writes on several register kinds
    load(4'd15, 40'h000000FFFF);
    op_i(3'd2, 4'd15, 6'd15, "R3 clear tmp3 bit15");
    op_i(3'd1, 4'd2, 6'd39, "R3 set acc2 bit39");
    op_i(3'd3, 4'd2, 6'd0, "R3 invert acc2 bit0");
    op_i(3'd3, 4'd2, 6'd0, "R3 invert acc2 bit0 back");
    op_i(3'd1, 4'd11, 6'd7, "R3 R8 set aux7 bit7");
    idle();

    // R6: position from a pointer register
    load(4'd8, 40'd2);
    load(4'd3, 40'h0000000004);
    op_p(3'd0, 4'd3, 3'd4, "R6 test via pointer");
    op_p(3'd4, 4'd3, 3'd4, "R6 pair via pointer");
    load(4'd8, 40'd39);
    op_p(3'd1, 4'd3, 3'd4, "R6 set bit39 via pointer");
    idle();

    // R4: single test leaves tc2
    op_i(3'd4, 4'd1, 6'd1, "R4 pair sets tc2");
    op_i(3'd0, 4'd1, 6'd0, "R4 single test keeps tc2");
    idle();

    // R7: range and code errors
    op_i(3'd1, 4'd5, 6'd16, "R7 set aux beyond width");
    op_i(3'd4, 4'd5, 6'd15, "R7 pair aux top");
    op_i(3'd4, 4'd5, 6'd14, "R7 pair aux in range");
    op_i(3'd4, 4'd1, 6'd39, "R7 pair acc top");
    op_i(3'd0, 4'd1, 6'd39, "R7 test acc bit39");
    op_i(3'd5, 4'd1, 6'd0, "R7 undefined code");
    op_i(3'd7, 4'd2, 6'd3, "R7 undefined code 7");
    load(4'd8, 40'h100);
    op_p(3'd3, 4'd3, 3'd4, "R7 pointer beyond width");
    op_i(3'd0, 4'd5, 6'd0, "R7 aux1 unchanged");
    op_i(3'd0, 4'd3, 6'd0, "R7 acc3 unchanged");
    idle();

    // R10: load and operation in the same cycle
    issue(1'b1, 4'd12, 40'h00FF, 1'b1, 3'd1, 4'd12, 1'b0, 6'd8, 3'd0,
          "R10 set wins over load");
    op_i(3'd0, 4'd12, 6'd0, "R10 readback tmp0");
    load(4'd8, 40'd3);
    issue(1'b1, 4'd8, 40'h30, 1'b1, 3'd0, 4'd1, 1'b1, 6'd0, 3'd4,
          "R10 pointer uses old value");
    op_i(3'd0, 4'd8, 6'd0, "R10 load kept beside test");
    issue(1'b1, 4'd13, 40'h1234, 1'b1, 3'd2, 4'd3, 1'b0, 6'd2, 3'd0,
          "R10 write other target");
    op_i(3'd0, 4'd13, 6'd0, "R10 other load kept");
    idle();

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R9 all results seen", 40'(sb.size()), 40'h0);
    finish_run();
  end

endmodule